// File: doc/BRIEF.md
# Multiplexed Byte-Bus Access Controller

The controller carries single-byte reads and writes from a host to one of two peripherals that share a narrow parallel bus. That bus has eight bidirectional data lines, two address latch strobes, two active-low chip selects, active-low read and write strobes, and an active-low acknowledge coming back. The address is 16 bits wide. It is sent as two byte phases on the data lines: the low byte goes first with its own latch strobe, then the high byte with the other strobe. After the address, the block either keeps driving the write byte or releases the lines. It then selects the device and pulses the read or write strobe until the peripheral acknowledges.

The host starts a transaction by raising `req_i` for one cycle while the controller is idle. The controller ignores requests while a transaction is in progress. On completion, `ready_o` is high for exactly one cycle. `rdata_o` then holds the byte sampled on the lines for a read, and `tmo_o` shows whether the acknowledge failed to arrive within the timeout window. The acknowledge input is resynchronised through two flops. Strobe width and timeout length are parameters counted in clock cycles.

Top module: `mbus_ctrl`

## Requirements
- R1: Out of reset and while idle, `cs0_no`, `cs1_no`, `rd_no` and `wr_no` are 1. `alo_stb_o`, `ahi_stb_o`, `bus_oe_o` and `ready_o` are 0.
- R2: A transaction first presents `addr_i[7:0]` on `bus_d_o` with `bus_oe_o`=1 and raises `alo_stb_o` for exactly STB_CYC cycles. The same byte is on the lines in the cycle before the strobe rises and in the cycle after it falls.
- R3: After the low phase, `addr_i[15:8]` is presented and `ahi_stb_o` is raised, with the same width and the same setup and hold rule as in R2.
- R4: For a write (`we_i`=1), `bus_oe_o` stays 1 and `bus_d_o` carries `wdata_i` while `wr_no` is low. For a read (`we_i`=0), `bus_oe_o` is 0 whenever `rd_no` is low.
- R5: `dev_i`=0 selects `cs0_no` and `dev_i`=1 selects `cs1_no`. Only one select is ever low. The select goes low at least one cycle before the read or write strobe.
- R6: Once the synchronised `ack_ni` is seen low, the transaction ends. A read captures `bus_d_i` into `rdata_o`. `ready_o` is high for one cycle, and `tmo_o` is 0.
- R7: If no acknowledge is seen, the strobe stays low for exactly TMO_CYC cycles. The transaction then ends with `ready_o`=1 and `tmo_o`=1, and a read reports the value then present on `bus_d_i`.
- R8: In the cycle in which `ready_o` is 1, all four control lines are already back at 1, after at least one of them was low in the previous cycle.
- R9: A `req_i` pulse while a transaction is in progress is ignored. It starts no bus cycle and does not change the address, device or direction of the transaction under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request, accepted only when idle |
| addr_i | input | 16 | Transaction address (2*DW) |
| wdata_i | input | 8 | Write byte |
| we_i | input | 1 | 1 = write, 0 = read |
| dev_i | input | 1 | Device select: 0 or 1 |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Byte captured by the last read |
| tmo_o | output | 1 | Last transaction ended on timeout |
| bus_d_o | output | 8 | Data lines, driven value |
| bus_d_i | input | 8 | Data lines, sampled value |
| bus_oe_o | output | 1 | Output enable for the data lines |
| alo_stb_o | output | 1 | Low address byte latch strobe, active high |
| ahi_stb_o | output | 1 | High address byte latch strobe, active high |
| cs0_no | output | 1 | Chip select device 0, active low |
| cs1_no | output | 1 | Chip select device 1, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| ack_ni | input | 1 | Peripheral acknowledge, active low, asynchronous |

## Verification
Some rules are checked on every cycle: that at most one chip select is low, that a select leads its strobe, that the data lines are released under a read strobe, that the control lines are released together when the ready pulse comes, that the pulse is a single cycle, and that the latched request is held while busy. A peripheral model in the bench is needed for the rest. It has to recover the address from the two latch phases and measure strobe widths and data setup and hold. It also checks that read data returns once the acknowledge has crossed the synchroniser, measures the exact timeout window, and confirms that a request issued mid-transaction adds no second bus cycle.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LO_SET,
    ST_LO_STB,
    ST_LO_HLD,
    ST_HI_SET,
    ST_HI_STB,
    ST_HI_HLD,
    ST_DATA,
    ST_CSEL,
    ST_WAIT
  } mbus_st_e;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mbus_cnt.sv
module mbus_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_o <= '0;
    else if (clr_i)       q_o <= '0;
    else if (q_o != '1)   q_o <= q_o + 1'b1;  // saturate
  end
endmodule

// File: rtl/mbus_fsm.sv
module mbus_fsm
  import mbus_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned CW      = 8,
  parameter int unsigned STB_CYC = 2,
  parameter int unsigned TMO_CYC = 100,
  localparam int unsigned AW     = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          dev_i,
  input  logic          ack_low_i,
  input  logic [CW-1:0] cnt_i,
  output logic          cnt_clr_o,
  input  logic [DW-1:0] bus_d_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic          tmo_o,
  output logic [DW-1:0] bus_d_o,
  output logic          bus_oe_o,
  output logic          alo_stb_o,
  output logic          ahi_stb_o,
  output logic          cs0_no,
  output logic          cs1_no,
  output logic          rd_no,
  output logic          wr_no
);
  localparam logic [CW-1:0] STB_LAST = CW'(STB_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYC - 1);

  mbus_st_e      state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          we_q, dev_q;
  logic          fin, fin_tmo;

  assign fin_tmo = (state_q == ST_WAIT) && !ack_low_i && (cnt_i == TMO_LAST);
  assign fin     = (state_q == ST_WAIT) && (ack_low_i || cnt_i == TMO_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i) state_d = ST_LO_SET;
      ST_LO_SET: state_d = ST_LO_STB;
      ST_LO_STB: if (cnt_i == STB_LAST) state_d = ST_LO_HLD;
      ST_LO_HLD: state_d = ST_HI_SET;
      ST_HI_SET: state_d = ST_HI_STB;
      ST_HI_STB: if (cnt_i == STB_LAST) state_d = ST_HI_HLD;
      ST_HI_HLD: state_d = ST_DATA;
      ST_DATA:   state_d = ST_CSEL;
      ST_CSEL:   state_d = ST_WAIT;
      ST_WAIT:   if (fin) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign cnt_clr_o = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      dev_q   <= 1'b0;
      ready_o <= 1'b0;
      rdata_o <= '0;
      tmo_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_o <= fin;
      if (state_q == ST_IDLE && req_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        we_q    <= we_i;
        dev_q   <= dev_i;
      end
      if (fin) begin
        tmo_o <= fin_tmo;
        if (!we_q) rdata_o <= bus_d_i;
      end
    end
  end

  logic in_lo, in_hi, in_dat, sel_on, stb_on;
  assign in_lo  = state_q inside {ST_LO_SET, ST_LO_STB, ST_LO_HLD};
  assign in_hi  = state_q inside {ST_HI_SET, ST_HI_STB, ST_HI_HLD};
  assign in_dat = state_q inside {ST_DATA, ST_CSEL, ST_WAIT};
  assign sel_on = state_q inside {ST_CSEL, ST_WAIT};
  assign stb_on = (state_q == ST_WAIT);

  always_comb begin
    bus_d_o = '0;
    if (in_lo)              bus_d_o = addr_q[DW-1:0];
    else if (in_hi)         bus_d_o = addr_q[AW-1:DW];
    else if (in_dat && we_q) bus_d_o = wdata_q;
  end

  assign bus_oe_o  = in_lo || in_hi || (in_dat && we_q);
  assign alo_stb_o = (state_q == ST_LO_STB);
  assign ahi_stb_o = (state_q == ST_HI_STB);
  assign cs0_no    = !(sel_on && !dev_q);
  assign cs1_no    = !(sel_on && dev_q);
  assign rd_no     = !(stb_on && !we_q);
  assign wr_no     = !(stb_on && we_q);

  a_r1_latch_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alo_stb_o && ahi_stb_o));

  a_r4_read_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !bus_oe_o);

  a_r5_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!cs0_no && !cs1_no));

  a_r5_select_leads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_no) || $fell(wr_no)) |-> ($past(!cs0_no) || $past(!cs1_no)));

  a_r6_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  a_r8_release_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cs0_no && cs1_no && rd_no && wr_no && $past(!rd_no || !wr_no)));

  a_r9_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> ($stable(addr_q) && $stable(we_q) && $stable(dev_q)));
endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl #(
  parameter int unsigned DW       = 8,
  parameter int unsigned STB_CYC  = 2,
  parameter int unsigned TMO_CYC  = 50000,
  parameter int unsigned SYNC_STG = 2,
  localparam int unsigned AW      = 2 * DW,
  localparam int unsigned CMAX    = (TMO_CYC > STB_CYC) ? TMO_CYC : STB_CYC,
  localparam int unsigned CW      = $clog2(CMAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          dev_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic          tmo_o,
  output logic [DW-1:0] bus_d_o,
  input  logic [DW-1:0] bus_d_i,
  output logic          bus_oe_o,
  output logic          alo_stb_o,
  output logic          ahi_stb_o,
  output logic          cs0_no,
  output logic          cs1_no,
  output logic          rd_no,
  output logic          wr_no,
  input  logic          ack_ni
);
  logic          ack_s;
  logic          cnt_clr;
  logic [CW-1:0] cnt;

  mbus_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_ni),
    .q_o   (ack_s)
  );

  mbus_cnt #(.CW(CW)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .q_o   (cnt)
  );

  mbus_fsm #(
    .DW(DW), .CW(CW), .STB_CYC(STB_CYC), .TMO_CYC(TMO_CYC)
  ) i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .we_i     (we_i),
    .dev_i    (dev_i),
    .ack_low_i(!ack_s),
    .cnt_i    (cnt),
    .cnt_clr_o(cnt_clr),
    .bus_d_i  (bus_d_i),
    .ready_o  (ready_o),
    .rdata_o  (rdata_o),
    .tmo_o    (tmo_o),
    .bus_d_o  (bus_d_o),
    .bus_oe_o (bus_oe_o),
    .alo_stb_o(alo_stb_o),
    .ahi_stb_o(ahi_stb_o),
    .cs0_no   (cs0_no),
    .cs1_no   (cs1_no),
    .rd_no    (rd_no),
    .wr_no    (wr_no)
  );
endmodule

// File: tb/test_mbus_ctrl.sv
module test_mbus_ctrl;
  localparam int CLK_PER = 10;
  localparam int STB     = 3;
  localparam int TMO     = 40;
  localparam logic [7:0] IDLE_PAT = 8'hC3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, dev = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, bus_di = IDLE_PAT;
  logic ack_n = 1'b1;
  logic ready, tmo, oe, alo, ahi, cs0_n, cs1_n, rd_n, wr_n;
  logic [7:0] rdata, bus_do;

  always #(CLK_PER/2) clk = ~clk;

  mbus_ctrl #(.STB_CYC(STB), .TMO_CYC(TMO)) i_mbus_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .dev_i(dev), .ready_o(ready), .rdata_o(rdata), .tmo_o(tmo),
    .bus_d_o(bus_do), .bus_d_i(bus_di), .bus_oe_o(oe), .alo_stb_o(alo),
    .ahi_stb_o(ahi), .cs0_no(cs0_n), .cs1_no(cs1_n), .rd_no(rd_n),
    .wr_no(wr_n), .ack_ni(ack_n)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic        we;
    logic        dev;
    logic [7:0]  wd;
    logic        tmo;
  } exp_t;

  exp_t exp_q[$];
  int n_tests = 0, n_fail = 0, done_cnt = 0, txn_cnt = 0, ack_dly = 0;
  bit finished = 0;

  function automatic logic [7:0] periph_rd(input logic [7:0] lo, input logic [7:0] hi);
    return lo ^ {hi[3:0], hi[7:4]} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // peripheral model state
  logic [7:0] p_lo, p_hi, p_wd, pv_d;
  bit pv_alo, pv_ahi, pv_stb, pv_cs, pv_rdy;
  bit lo_pre, lo_post, hi_pre, hi_post, cs_lead, oe_ok, p_cs0, p_cs1, acked;
  int lo_len, hi_len, stb_len, wcnt;

  always @(negedge clk) begin
    bit stb;
    exp_t e;
    if (rst_n) begin
      // monitor
      if (pv_rdy && ready) chk(0, "R6 ready longer than one cycle", 1, 0);
      if (ready) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected completion", 1, 0);
        else begin
          e = exp_q.pop_front();
          done_cnt++;
          chk(cs0_n && cs1_n && rd_n && wr_n, "R8 controls released at ready",
              {cs0_n, cs1_n, rd_n, wr_n}, 4'hF);
          chk(tmo == e.tmo, e.tmo ? "R7 timeout flag" : "R6 timeout flag", tmo, e.tmo);
          chk(p_lo == e.addr[7:0] && lo_pre && lo_post, "R2 low address phase",
              {lo_pre, lo_post, p_lo}, {2'b11, e.addr[7:0]});
          chk(lo_len == STB, "R2 low strobe width", lo_len, STB);
          chk(p_hi == e.addr[15:8] && hi_pre && hi_post, "R3 high address phase",
              {hi_pre, hi_post, p_hi}, {2'b11, e.addr[15:8]});
          chk(hi_len == STB, "R3 high strobe width", hi_len, STB);
          chk(p_cs0 == !e.dev && p_cs1 == e.dev && cs_lead, "R5 chip select",
              {cs_lead, p_cs1, p_cs0}, {1'b1, e.dev, !e.dev});
          chk(oe_ok, "R4 data line direction", oe_ok, 1);
          if (e.we) chk(p_wd == e.wd, "R4 write byte", p_wd, e.wd);
          else if (e.tmo) chk(rdata == IDLE_PAT, "R7 timeout read data", rdata, IDLE_PAT);
          else chk(rdata == periph_rd(e.addr[7:0], e.addr[15:8]), "R6 read data",
                   rdata, periph_rd(e.addr[7:0], e.addr[15:8]));
          if (e.tmo) chk(stb_len == TMO, "R7 timeout window", stb_len, TMO);
        end
      end
      // peripheral
      stb = !rd_n || !wr_n;
      if (alo && !pv_alo) begin
        lo_pre = (pv_d == bus_do) && oe; lo_len = 0; p_lo = bus_do;
      end
      if (alo) lo_len++;
      if (!alo && pv_alo) lo_post = (bus_do == p_lo);
      if (ahi && !pv_ahi) begin
        hi_pre = (pv_d == bus_do) && oe; hi_len = 0; p_hi = bus_do;
      end
      if (ahi) hi_len++;
      if (!ahi && pv_ahi) hi_post = (bus_do == p_hi);
      if (stb && !pv_stb) begin
        cs_lead = pv_cs; stb_len = 0; wcnt = 0; acked = 0; oe_ok = 1;
        p_cs0 = !cs0_n; p_cs1 = !cs1_n; txn_cnt++;
      end
      if (stb) begin
        stb_len++;
        if (!wr_n) begin oe_ok = oe_ok && oe; p_wd = bus_do; end
        if (!rd_n) oe_ok = oe_ok && !oe;
        if (ack_dly >= 0 && wcnt == ack_dly && !acked) begin
          acked = 1; ack_n = 1'b0; bus_di = periph_rd(p_lo, p_hi);
        end
        wcnt++;
      end else begin
        ack_n = 1'b1; bus_di = IDLE_PAT;
      end
      pv_d = bus_do; pv_alo = alo; pv_ahi = ahi; pv_stb = stb;
      pv_cs = !cs0_n || !cs1_n; pv_rdy = ready;
    end
  end

  task automatic do_txn(input logic [15:0] a, input bit w, input bit d,
                        input logic [7:0] wd, input int dly);
    exp_t e;
    int n0;
    ack_dly = dly;
    e = '{addr: a, we: w, dev: d, wd: wd, tmo: (dly < 0)};
    exp_q.push_back(e);
    n0 = done_cnt;
    @(negedge clk);
    req = 1'b1; addr = a; we = w; dev = d; wdata = wd;
    @(negedge clk);
    req = 1'b0; addr = ~a; wdata = ~wd;
    while (done_cnt == n0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cs0_n && cs1_n && rd_n && wr_n && !alo && !ahi && !oe && !ready,
        "R1 reset state", {cs0_n, cs1_n, rd_n, wr_n, alo, ahi, oe, ready}, 8'hF0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs0_n && cs1_n && rd_n && wr_n && !alo && !ahi && !oe && !ready,
        "R1 idle state", {cs0_n, cs1_n, rd_n, wr_n, alo, ahi, oe, ready}, 8'hF0);

    do_txn(16'h12A5, 1'b1, 1'b0, 8'h5E, 2);   // write dev0
    do_txn(16'hBEEF, 1'b0, 1'b1, 8'h00, 0);   // read dev1, immediate ack
    do_txn(16'h00FF, 1'b0, 1'b0, 8'h00, 7);   // read dev0
    do_txn(16'hFF00, 1'b1, 1'b1, 8'hA1, 5);   // write dev1
    do_txn(16'h3C4D, 1'b0, 1'b1, 8'h00, -1);  // R7 read timeout
    do_txn(16'h8001, 1'b1, 1'b0, 8'h77, -1);  // R7 write timeout
    do_txn(16'h5AA5, 1'b0, 1'b0, 8'h00, 1);   // back after timeout

    // R9: request while busy
    t0 = txn_cnt;
    ack_dly = 10;
    exp_q.push_back('{addr: 16'h0246, we: 1'b0, dev: 1'b0, wd: 8'h00, tmo: 1'b0});
    @(negedge clk);
    req = 1'b1; addr = 16'h0246; we = 1'b0; dev = 1'b0;
    @(negedge clk);
    req = 1'b0;
    repeat (6) @(negedge clk);
    req = 1'b1; addr = 16'hDEAD; we = 1'b1; dev = 1'b1; wdata = 8'h99;
    @(negedge clk);
    req = 1'b0;
    while (done_cnt == 8) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(txn_cnt - t0 == 1, "R9 busy request ignored", txn_cnt - t0, 1);
    chk(exp_q.size() == 0, "R9 no pending completion", exp_q.size(), 0);
    chk(cs1_n && wr_n && !oe, "R9 bus idle after ignored request",
        {cs1_n, wr_n, oe}, 3'b110);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule